// File: doc/BRIEF.md
# Alarm Match Unit

This block holds four alarm settings: minute, hour, day of month and day of week. It compares them with the live BCD time fields of a clock counter. Each setting has its own disable bit. A set disable bit removes that setting from the comparison. The comparison runs only when the clock counter pulses its once-per-minute strobe. The block sets a sticky alarm flag when every enabled field equals its live value. If the interrupt-enable bit is set, the block also drives an active-low interrupt request. Software clears the flag through the register port. The open-drain pad and the serial host bus are outside the block.

The host reaches the block through a small register port. A write is a one-cycle valid pulse and is always accepted, so there is no back-pressure on writes. A read request is also always accepted. Its data comes back one cycle later with a one-cycle valid pulse. The host must take the data in that cycle, because the response path has no ready signal. Register map: address 0 is control, address 1 is alarm minute, address 2 is alarm hour, address 3 is alarm day of month and address 4 is alarm day of week. Addresses 5 to 7 read as zero and ignore writes.

Top module: `alarm_match`

## Requirements
- R1: After reset, each alarm register (addresses 1-4) reads 0x80, with its disable bit 7 set and its value zero. The control register reads 0x00 and irq_n is 1.
- R2: Alarm registers read back what was written, with unimplemented bits read as 0. The value bits are 6:0 for minute, 5:0 for hour, 5:0 for day of month and 2:0 for day of week. Bit 7 is the disable bit.
- R3: The alarm flag is control bit 3. It reads 1 from the cycle after a min_tick in which every enabled field equals its live field.
- R4: A field whose disable bit 7 is 1 takes no part in the comparison, whatever its live value is.
- R5: A min_tick with any enabled field not equal to its live value does not set the flag.
- R6: When all four disable bits are 1, the flag is never set.
- R7: Live fields that match are ignored unless min_tick is high.
- R8: The flag is set only on a min_tick where the match condition turns from false to true. A match that lasts across ticks does not set the flag again after it is cleared. A tick that does not match re-arms it.
- R9: Writing control with bit 3 = 0 clears the flag. Writing bit 3 = 1 leaves the flag unchanged.
- R10: irq_n is 0 exactly when the flag is 1 and the interrupt-enable bit (control bit 1) is 1.
- R11: If a flag-setting tick and a flag-clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write valid, always accepted |
| rd_en | input | 1 | Register read request, always accepted |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after rd_en |
| rd_data | output | 8 | Read response data |
| live_min | input | 7 | Live minute, BCD |
| live_hour | input | 6 | Live hour, BCD |
| live_date | input | 6 | Live day of month, BCD |
| live_wday | input | 3 | Live day of week |
| min_tick | input | 1 | Once-per-minute evaluation strobe |
| irq_n | output | 1 | Active-low alarm interrupt request |

## Verification
The bench holds a match in place across several ticks, and then clears the flag between those ticks. A design that sets the flag on the level of the match would show the flag set again after the clear. It also runs a tick that does not match and then one that does, to check that the alarm re-arms. A tick that sets the flag lands in the same cycle as a write that clears it. A design that lets the clear win there would lose the alarm. The bench also tests the case with every field disabled, which a naive AND of field hits would take as a match. Finally it writes the control register with the flag bit at 1 and checks that this neither clears nor sets the flag.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int DW         = 8;
  localparam int AW         = 3;
  localparam int DIS_BIT    = 7;
  localparam int FLAG_BIT   = 3;
  localparam int IE_BIT     = 1;

  typedef enum logic [AW-1:0] {
    ADR_CTRL = 3'd0,
    ADR_MIN  = 3'd1,
    ADR_HOUR = 3'd2,
    ADR_DATE = 3'd3,
    ADR_WDAY = 3'd4
  } alarm_addr_e;

  function automatic int fld_width(input int idx);
    case (idx)
      0:       return 7;
      1:       return 6;
      2:       return 6;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/alarm_field.sv
module alarm_field #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         wr_dis,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] live,
  output logic         dis,
  output logic [W-1:0] val,
  output logic         hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis <= 1'b1;
      val <= '0;
    end else if (wr) begin
      dis <= wr_dis;
      val <= wr_val;
    end
  end

  assign hit = dis | (val == live);
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic clr,
  output logic flag,
  output logic prev_match
);
  logic set_evt;

  assign set_evt = tick & match & ~prev_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_match <= 1'b0;
      flag       <= 1'b0;
    end else begin
      if (tick) prev_match <= match;
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [6:0]    live_min,
  input  logic [5:0]    live_hour,
  input  logic [5:0]    live_date,
  input  logic [2:0]    live_wday,
  input  logic          min_tick,
  output logic          irq_n
);
  logic [NUM_FIELDS-1:0] hit_vec;
  logic [NUM_FIELDS-1:0] dis_vec;
  logic [DW-1:0]         fld_word [NUM_FIELDS];
  logic                  match_all;
  logic                  ie_q;
  logic                  flag_q;
  logic                  prev_match;
  logic                  ctrl_wr;
  logic [DW-1:0]         rd_next;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int W = fld_width(i);
    logic [W-1:0] lv;
    logic [W-1:0] v;
    if (i == 0)      begin : g_l0 assign lv = live_min;  end
    else if (i == 1) begin : g_l1 assign lv = live_hour; end
    else if (i == 2) begin : g_l2 assign lv = live_date; end
    else             begin : g_l3 assign lv = live_wday; end

    alarm_field #(.W(W)) u_field (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_en && (addr == AW'(i + 1))),
      .wr_dis (wdata[DIS_BIT]),
      .wr_val (wdata[W-1:0]),
      .live   (lv),
      .dis    (dis_vec[i]),
      .val    (v),
      .hit    (hit_vec[i])
    );
    assign fld_word[i] = {dis_vec[i], 7'(v)};
  end

  assign match_all = (&hit_vec) & ~(&dis_vec);
  assign ctrl_wr   = wr_en && (addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (ctrl_wr) ie_q <= wdata[IE_BIT];
  end

  alarm_flag_ctl u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (min_tick),
    .match      (match_all),
    .clr        (ctrl_wr && !wdata[FLAG_BIT]),
    .flag       (flag_q),
    .prev_match (prev_match)
  );

  always_comb begin
    rd_next = '0;
    case (addr)
      ADR_CTRL: begin
        rd_next[FLAG_BIT] = flag_q;
        rd_next[IE_BIT]   = ie_q;
      end
      ADR_MIN:  rd_next = fld_word[0];
      ADR_HOUR: rd_next = fld_word[1];
      ADR_DATE: rd_next = fld_word[2];
      ADR_WDAY: rd_next = fld_word[3];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  assign irq_n = ~(flag_q & ie_q);
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       min_tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       irq_n,
  input logic       flag,
  input logic       ie,
  input logic       match,
  input logic       prev_match,
  input logic [3:0] dis_vec
);
  // R3 and R11: a rising match at a tick leaves the flag set, even with a clear in the same cycle
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && match && !prev_match) |=> flag);

  // R7: the flag rises only after a tick
  a_r7_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(min_tick));

  // R6: with every field disabled the flag never rises
  a_r6_all_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(dis_vec != 4'hF));

  // R9: the flag falls only after a control write with bit 3 at 0
  a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && addr == 3'd0 && !wdata[3]));

  // R10: an asserted request implies a set flag and an enabled interrupt
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag && ie));
endmodule

bind alarm_match alarm_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .min_tick   (min_tick),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .irq_n      (irq_n),
  .flag       (flag_q),
  .ie         (ie_q),
  .match      (match_all),
  .prev_match (prev_match),
  .dis_vec    (dis_vec)
);

// File: tb/alarm_match_test.sv
module alarm_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [6:0] live_min = '0;
  logic [5:0] live_hour = '0;
  logic [5:0] live_date = '0;
  logic [2:0] live_wday = '0;
  logic       min_tick = 1'b0;
  logic       irq_n;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #2.5 clk = ~clk;

  alarm_match uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .live_min(live_min), .live_hour(live_hour), .live_date(live_date),
    .live_wday(live_wday), .min_tick(min_tick), .irq_n(irq_n)
  );

  // monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read response %02h", rd_data);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        if (rd_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s: read %02h expected %02h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_checks++;
    if (irq_n !== e) begin
      n_fail++;
      $display("FAIL %s: irq_n %b expected %b", tag, irq_n, e);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h80, "R1 min");
    rd(3'd2, 8'h80, "R1 hour");
    rd(3'd3, 8'h80, "R1 date");
    rd(3'd4, 8'h80, "R1 wday");
    chk_irq(1'b1, "R1 irq");
    // R2 read-back masks
    wr(3'd1, 8'hFF); rd(3'd1, 8'hFF, "R2 min");
    wr(3'd2, 8'hFF); rd(3'd2, 8'hBF, "R2 hour");
    wr(3'd3, 8'hFF); rd(3'd3, 8'hBF, "R2 date");
    wr(3'd4, 8'hFF); rd(3'd4, 8'h87, "R2 wday");
    // minute+hour enabled, date/wday disabled
    wr(3'd1, 8'h30); wr(3'd2, 8'h12); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
    wr(3'd0, 8'h00);
    live_min = 7'h30; live_hour = 6'h12; live_date = 6'h05; live_wday = 3'd3;
    repeat (3) @(negedge clk);
    rd(3'd0, 8'h00, "R7 no tick no flag");
    tick();
    rd(3'd0, 8'h08, "R3 R4 match sets flag");
    chk_irq(1'b1, "R10 ie off");
    wr(3'd0, 8'h0A);
    rd(3'd0, 8'h0A, "R9 write one keeps flag");
    chk_irq(1'b0, "R10 irq asserted");
    wr(3'd0, 8'h02);
    rd(3'd0, 8'h02, "R9 write zero clears");
    chk_irq(1'b1, "R10 irq released");
    tick();
    rd(3'd0, 8'h02, "R8 lasting match no reset");
    live_min = 7'h31;
    tick();
    rd(3'd0, 8'h02, "R5 mismatch no flag");
    live_min = 7'h30;
    tick();
    rd(3'd0, 8'h0A, "R8 re-armed match sets");
    wr(3'd0, 8'h02);
    // R6 all disabled
    wr(3'd1, 8'hB0); wr(3'd2, 8'h92);
    tick(); tick();
    rd(3'd0, 8'h02, "R6 all disabled never fires");
    // R4 weekday only, other live fields unrelated
    live_min = 7'h45; live_hour = 6'h07;
    wr(3'd4, 8'h03);
    tick();
    rd(3'd0, 8'h0A, "R4 wday-only match");
    wr(3'd0, 8'h02);
    live_wday = 3'd4;
    tick();
    rd(3'd0, 8'h02, "R5 wday mismatch");
    live_wday = 3'd3;
    // R11 tick and clear in the same cycle
    @(negedge clk);
    min_tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h02;
    @(negedge clk);
    min_tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, 8'h0A, "R11 set beats clear");
    chk_irq(1'b0, "R11 irq");
    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: %0d responses missing, expected 0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule